// File: doc/BRIEF.md
# Stochastic Binary-Input Two-Layer Perceptron

This block runs inference for a small two-layer perceptron whose neurons are all binary. Software first loads 32 input features, each an 8-bit fraction read as the probability that its input bit is 1. It also loads the signed 3-bit weights of both layers. Each weight is held as two non-negative magnitudes, one on a positive branch and one on a negative branch. A neuron fires only when its positive-branch sum is strictly larger than its negative-branch sum.

A run is started with a frame count N. For every frame, a bank of per-input linear feedback shift registers draws a fresh random bit for each of the 32 inputs. The 16 hidden neurons evaluate that bit vector and their outputs are captured. The 5 class neurons then evaluate the captured hidden vector. Each class neuron that fires adds one to its own counter.

When the last frame is done, a one-cycle done pulse marks the counters as final. The block also reports the index of the largest counter. Class scores are therefore spike counts over N repeated binary passes. No multi-bit activation is used anywhere.

Top module: `stbp_engine`

## Requirements
- R1: After reset, busy and done are 0, all five class counters are 0 and the class index is 0.
- R2: For each frame, input bit i is 1 when a draw from input i's own generator, uniform over 0..254, is less than feature i. A feature of 0 therefore never produces a 1, and a feature of 255 always produces a 1.
- R3: Each class counter is 8 bits wide and never wraps. A run of 255 frames in which a class fires every frame leaves that counter at 255.
- R4: A neuron in either layer outputs 1 only when the sum of its positive magnitudes over active inputs is strictly greater than the sum of its negative magnitudes. Equal sums give 0.
- R5: The 16 hidden outputs of a frame are the only inputs of the 5 class neurons in that frame. Class counter c (bits 8c+7..8c of class_cnt) ends the run equal to the number of frames in which class neuron c fired.
- R6: Weights are written through the weight port. wt_layer 0 selects the hidden layer (row = hidden neuron 0..15, column = input 0..31). wt_layer 1 selects the class layer (row = class 0..4, column = hidden neuron 0..15). wt_pos and wt_neg are magnitudes 0..7. Features are written through the feature port, where feat_addr selects the input.
- R7: A start seen while idle with frames = N > 0 raises busy in the next cycle. Each frame takes 3 cycles. done is high for exactly one cycle, the (3N+1)th cycle after the start edge, and the block is idle again after it.
- R8: A start with frames = 0 clears the counters and gives the done pulse in the first cycle after the start edge.
- R9: class_idx is the index of the largest class counter. On ties, the lowest index wins.
- R10: Feature writes, weight writes and start are ignored while busy or done is high.
- R11: Every start reseeds all generators. Two runs with the same features, weights and frame count give identical counters, and a feature of 128 makes a neuron fed only by that input fire in roughly half the frames.
- R12: Counters are cleared by an accepted start and hold their values from the done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_we | input | 1 | Feature write strobe |
| feat_addr | input | 5 | Input index of the feature written |
| feat_val | input | 8 | Feature value, probability in 1/255 steps |
| wt_we | input | 1 | Weight write strobe |
| wt_layer | input | 1 | 0 = hidden layer, 1 = class layer |
| wt_row | input | 4 | Neuron index within the selected layer |
| wt_col | input | 5 | Input index of that neuron |
| wt_pos | input | 3 | Positive-branch magnitude |
| wt_neg | input | 3 | Negative-branch magnitude |
| start | input | 1 | Run request, taken only while idle |
| frames | input | 8 | Number of stochastic frames N for the run |
| busy | output | 1 | Frames are being evaluated |
| done | output | 1 | One-cycle pulse: counters are final |
| class_cnt | output | 40 | Five 8-bit class counters, class 0 in the low byte |
| class_idx | output | 3 | Index of the largest counter, lowest on ties |

## Verification
Weights and features of 0 or 255 make every frame deterministic, so counters must equal either N or 0. A single wrong hidden or class neuron shows up as a full-scale count error at the done pulse. A mistake in the frame sequencer or frame counter shifts the done pulse away from cycle 3N+1, and it is caught on the first run. Generator faults show up as a feature-0 input that fires, as a mid-probability count outside its expected band, or as two identical runs that disagree. An argmax or tie fault is visible on class_idx as soon as the counters settle.

// File: rtl/stbp_pkg.sv
package stbp_pkg;

    // Width of a feature value and of each per-input random generator.
    localparam int unsigned FEAT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DRAW = 3'd1,
        ST_HID  = 3'd2,
        ST_OUT  = 3'd3,
        ST_FIN  = 3'd4
    } stbp_state_e;

    // One Galois step of a maximal-length 8-bit generator (x^8+x^6+x^5+x^4+1).
    function automatic logic [FEAT_W-1:0] gen_step(input logic [FEAT_W-1:0] s);
        logic [FEAT_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 8'hB8;
        return n;
    endfunction

    // Distinct non-zero start value for generator idx.
    function automatic logic [FEAT_W-1:0] gen_seed(input int unsigned idx);
        int unsigned v;
        v = ((idx * 29) + 5) % 255 + 1;
        return FEAT_W'(v);
    endfunction

endpackage

// File: rtl/stbp_lfsr_bank.sv
module stbp_lfsr_bank #(
    parameter int N_IN = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       reseed,
    input  logic                                       advance,
    input  logic [N_IN-1:0][stbp_pkg::FEAT_W-1:0]      feat,
    output logic [N_IN-1:0]                            bits
);
    import stbp_pkg::*;

    typedef struct packed {
        logic [N_IN-1:0][FEAT_W-1:0] gen;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_IN; i++) begin
            if (reseed)
                bank_d.gen[i] = gen_seed(i);
            else if (advance)
                bank_d.gen[i] = gen_step(bank_q.gen[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IN; i++)
                bank_q.gen[i] <= gen_seed(i);
        end else begin
            bank_q <= bank_d;
        end
    end

    // Generator state 1..255 maps to a draw 0..254; the bit is set below the feature.
    for (genvar g = 0; g < N_IN; g++) begin : g_cmp
        logic [FEAT_W-1:0] draw;
        assign draw    = bank_q.gen[g] - FEAT_W'(1);
        assign bits[g] = draw < feat[g];
    end

endmodule

// File: rtl/stbp_layer.sv
module stbp_layer #(
    parameter int N_NEUR = 16,
    parameter int N_IN   = 32,
    parameter int W_BITS = 3,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [W_BITS-1:0] wr_pos,
    input  logic [W_BITS-1:0] wr_neg,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_NEUR-1:0] fire
);
    localparam int SUM_W = W_BITS + $clog2(N_IN + 1);

    typedef struct packed {
        logic [N_NEUR-1:0][N_IN-1:0][W_BITS-1:0] pos;
        logic [N_NEUR-1:0][N_IN-1:0][W_BITS-1:0] neg;
    } wstore_t;

    wstore_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        for (int n = 0; n < N_NEUR; n++) begin
            for (int c = 0; c < N_IN; c++) begin
                if (wr_en && wr_row == ROW_W'(n) && wr_col == COL_W'(c)) begin
                    w_d.pos[n][c] = wr_pos;
                    w_d.neg[n][c] = wr_neg;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // Differential evaluation: strict comparison, equal branches stay silent.
    always_comb begin
        logic [SUM_W-1:0] acc_p;
        logic [SUM_W-1:0] acc_n;
        for (int n = 0; n < N_NEUR; n++) begin
            acc_p = '0;
            acc_n = '0;
            for (int c = 0; c < N_IN; c++) begin
                if (in_vec[c]) begin
                    acc_p = acc_p + SUM_W'(w_q.pos[n][c]);
                    acc_n = acc_n + SUM_W'(w_q.neg[n][c]);
                end
            end
            fire[n] = acc_p > acc_n;
        end
    end

endmodule

// File: rtl/stbp_argmax.sv
module stbp_argmax #(
    parameter int N_OUT = 5,
    parameter int CNT_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_OUT-1:0][CNT_W-1:0] cnt,
    output logic [IDX_W-1:0]            idx
);
    always_comb begin
        logic [CNT_W-1:0] best;
        best = cnt[0];
        idx  = '0;
        for (int i = 1; i < N_OUT; i++) begin
            if (cnt[i] > best) begin
                best = cnt[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/stbp_engine.sv
module stbp_engine #(
    parameter int N_IN   = 32,
    parameter int N_HID  = 16,
    parameter int N_OUT  = 5,
    parameter int W_BITS = 3,
    parameter int CNT_W  = 8,
    localparam int FEAT_W = stbp_pkg::FEAT_W,
    localparam int IN_AW  = $clog2(N_IN),
    localparam int ROW_W  = ($clog2(N_HID) > $clog2(N_OUT)) ? $clog2(N_HID) : $clog2(N_OUT),
    localparam int IDX_W  = $clog2(N_OUT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     feat_we,
    input  logic [IN_AW-1:0]         feat_addr,
    input  logic [FEAT_W-1:0]        feat_val,
    input  logic                     wt_we,
    input  logic                     wt_layer,
    input  logic [ROW_W-1:0]         wt_row,
    input  logic [IN_AW-1:0]         wt_col,
    input  logic [W_BITS-1:0]        wt_pos,
    input  logic [W_BITS-1:0]        wt_neg,
    input  logic                     start,
    input  logic [CNT_W-1:0]         frames,
    output logic                     busy,
    output logic                     done,
    output logic [N_OUT*CNT_W-1:0]   class_cnt,
    output logic [IDX_W-1:0]         class_idx
);
    import stbp_pkg::*;

    typedef struct packed {
        stbp_state_e                 st;
        logic [N_IN-1:0][FEAT_W-1:0] feat;
        logic [N_IN-1:0]             in_vec;
        logic [N_HID-1:0]            hid;
        logic [CNT_W-1:0]            nfr;
        logic [CNT_W-1:0]            fcnt;
        logic [N_OUT-1:0][CNT_W-1:0] cnt;
    } core_t;

    core_t core_d, core_q;

    logic             idle;
    logic             reseed;
    logic             advance;
    logic             hid_we;
    logic             out_we;
    logic [N_IN-1:0]  draw_bits;
    logic [N_HID-1:0] hid_fire;
    logic [N_OUT-1:0] out_fire;

    assign idle   = core_q.st == ST_IDLE;
    assign hid_we = wt_we && idle && !wt_layer;
    assign out_we = wt_we && idle &&  wt_layer;

    stbp_lfsr_bank #(
        .N_IN (N_IN)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .advance (advance),
        .feat    (core_q.feat),
        .bits    (draw_bits)
    );

    stbp_layer #(
        .N_NEUR (N_HID),
        .N_IN   (N_IN),
        .W_BITS (W_BITS),
        .ROW_W  (ROW_W),
        .COL_W  (IN_AW)
    ) i_hidden (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hid_we),
        .wr_row (wt_row),
        .wr_col (wt_col),
        .wr_pos (wt_pos),
        .wr_neg (wt_neg),
        .in_vec (core_q.in_vec),
        .fire   (hid_fire)
    );

    stbp_layer #(
        .N_NEUR (N_OUT),
        .N_IN   (N_HID),
        .W_BITS (W_BITS),
        .ROW_W  (ROW_W),
        .COL_W  (IN_AW)
    ) i_class (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (out_we),
        .wr_row (wt_row),
        .wr_col (wt_col),
        .wr_pos (wt_pos),
        .wr_neg (wt_neg),
        .in_vec (core_q.hid),
        .fire   (out_fire)
    );

    stbp_argmax #(
        .N_OUT (N_OUT),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) i_argmax (
        .cnt (core_q.cnt),
        .idx (class_idx)
    );

    always_comb begin
        core_d  = core_q;
        reseed  = 1'b0;
        advance = 1'b0;

        if (feat_we && idle) begin
            for (int i = 0; i < N_IN; i++) begin
                if (feat_addr == IN_AW'(i)) core_d.feat[i] = feat_val;
            end
        end

        unique case (core_q.st)
            ST_IDLE: begin
                if (start) begin
                    core_d.cnt  = '0;
                    core_d.fcnt = '0;
                    core_d.nfr  = frames;
                    reseed      = 1'b1;
                    core_d.st   = (frames == '0) ? ST_FIN : ST_DRAW;
                end
            end
            ST_DRAW: begin
                core_d.in_vec = draw_bits;
                advance       = 1'b1;
                core_d.st     = ST_HID;
            end
            ST_HID: begin
                core_d.hid = hid_fire;
                core_d.st  = ST_OUT;
            end
            ST_OUT: begin
                for (int c = 0; c < N_OUT; c++) begin
                    if (out_fire[c]) core_d.cnt[c] = core_q.cnt[c] + CNT_W'(1);
                end
                core_d.fcnt = core_q.fcnt + CNT_W'(1);
                core_d.st   = (core_d.fcnt == core_q.nfr) ? ST_FIN : ST_DRAW;
            end
            ST_FIN: begin
                core_d.st = ST_IDLE;
            end
            default: begin
                core_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy      = (core_q.st == ST_DRAW) || (core_q.st == ST_HID) || (core_q.st == ST_OUT);
    assign done      = core_q.st == ST_FIN;
    assign class_cnt = core_q.cnt;

endmodule

// File: rtl/stbp_engine_chk.sv
module stbp_engine_chk #(
    parameter int N_OUT = 5,
    parameter int CNT_W = 8,
    parameter int IDX_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [CNT_W-1:0]       frames,
    input logic                   busy,
    input logic                   done,
    input logic [N_OUT*CNT_W-1:0] class_cnt,
    input logic [IDX_W-1:0]       class_idx
);
    logic             idle_v;
    logic [CNT_W-1:0] cnt_a [N_OUT];
    logic [CNT_W-1:0] win_cnt;

    assign idle_v = !busy && !done;

    for (genvar g = 0; g < N_OUT; g++) begin : g_unpack
        assign cnt_a[g] = class_cnt[g*CNT_W +: CNT_W];
    end

    always_comb begin
        win_cnt = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (class_idx == IDX_W'(i)) win_cnt = cnt_a[i];
        end
    end

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_start_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_v && start && frames != '0) |=> busy);

    assert_zero_frames_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_v && start && frames == '0) |=> (done && class_cnt == '0));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_v && !start) |=> $stable(class_cnt));

    assert_hold_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(class_cnt));

    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        class_idx < IDX_W'(N_OUT));

    for (genvar g = 0; g < N_OUT; g++) begin : g_cls
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && cnt_a[g] == {CNT_W{1'b1}}) |=> (cnt_a[g] == {CNT_W{1'b1}}));

        assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            busy |=> (cnt_a[g] == $past(cnt_a[g]) || cnt_a[g] == $past(cnt_a[g]) + CNT_W'(1)));

        assert_argmax_below_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (IDX_W'(g) < class_idx) |-> (cnt_a[g] < win_cnt));

        assert_argmax_above_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (IDX_W'(g) > class_idx) |-> (cnt_a[g] <= win_cnt));
    end

endmodule

bind stbp_engine stbp_engine_chk #(
    .N_OUT (N_OUT),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
) i_stbp_engine_chk (.*);

// File: tb/test_stbp_engine.sv
`timescale 1ns/1ps
module test_stbp_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_we = 1'b0;
    logic [4:0]  feat_addr = '0;
    logic [7:0]  feat_val = '0;
    logic        wt_we = 1'b0;
    logic        wt_layer = 1'b0;
    logic [3:0]  wt_row = '0;
    logic [4:0]  wt_col = '0;
    logic [2:0]  wt_pos = '0;
    logic [2:0]  wt_neg = '0;
    logic        start = 1'b0;
    logic [7:0]  frames = '0;
    logic        busy;
    logic        done;
    logic [39:0] class_cnt;
    logic [2:0]  class_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stbp_engine i_stbp_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .feat_we   (feat_we),
        .feat_addr (feat_addr),
        .feat_val  (feat_val),
        .wt_we     (wt_we),
        .wt_layer  (wt_layer),
        .wt_row    (wt_row),
        .wt_col    (wt_col),
        .wt_pos    (wt_pos),
        .wt_neg    (wt_neg),
        .start     (start),
        .frames    (frames),
        .busy      (busy),
        .done      (done),
        .class_cnt (class_cnt),
        .class_idx (class_idx)
    );

    function automatic int cnt_of(input int c);
        return int'(class_cnt[c*8 +: 8]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic set_feat(input int a, input int v);
        @(negedge clk);
        feat_we = 1'b1; feat_addr = 5'(a); feat_val = 8'(v);
        @(negedge clk);
        feat_we = 1'b0;
    endtask

    task automatic set_wt(input bit layer, input int row, input int col, input int p, input int n);
        @(negedge clk);
        wt_we = 1'b1; wt_layer = layer; wt_row = 4'(row); wt_col = 5'(col);
        wt_pos = 3'(p); wt_neg = 3'(n);
        @(negedge clk);
        wt_we = 1'b0;
    endtask

    task automatic clear_feats();
        for (int i = 0; i < 32; i++) set_feat(i, 0);
    endtask

    // Start a run; cyc = index of the cycle after the start edge in which done is seen.
    task automatic run(input int nfr, output int cyc, output bit busy1);
        @(negedge clk);
        start = 1'b1; frames = 8'(nfr);
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        busy1 = busy;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 done after reset", int'(done), 0);
        check_eq("R1 counters after reset", int'(class_cnt != '0), 0);
        check_eq("R1 class index after reset", int'(class_idx), 0);
    endtask

    task automatic t_load_weights();
        // hidden layer (R6 layer 0)
        set_wt(0, 0, 0, 3, 0);
        set_wt(0, 1, 0, 2, 2);
        set_wt(0, 2, 0, 0, 1);
        set_wt(0, 3, 5, 7, 0);
        set_wt(0, 3, 6, 0, 3);
        set_wt(0, 3, 7, 0, 3);
        set_wt(0, 4, 10, 1, 0);
        // class layer (R6 layer 1)
        set_wt(1, 0, 1, 4, 0);
        set_wt(1, 1, 2, 5, 0);
        set_wt(1, 2, 0, 1, 0);
        set_wt(1, 3, 0, 0, 1);
        set_wt(1, 3, 4, 1, 0);
        set_wt(1, 4, 0, 2, 2);
        set_wt(1, 4, 3, 1, 0);
    endtask

    task automatic t_basic();
        int cyc; bit b1;
        set_feat(0, 255);
        run(10, cyc, b1);
        check_eq("R7 busy in first cycle after start", int'(b1), 1);
        check_eq("R7 done cycle for 10 frames", cyc, 31);
        check_eq("R5 class 2 fires every frame", cnt_of(2), 10);
        check_eq("R4 hidden tie silences class 0", cnt_of(0), 0);
        check_eq("R4 negative-only hidden silences class 1", cnt_of(1), 0);
        check_eq("R4 negative class branch wins for class 3", cnt_of(3), 0);
        check_eq("R4 class-layer tie gives 0 for class 4", cnt_of(4), 0);
        check_eq("R9 class index single winner", int'(class_idx), 2);
        @(negedge clk);
        check_eq("R7 idle after done", int'(busy || done), 0);
    endtask

    task automatic t_hold();
        repeat (5) @(negedge clk);
        check_eq("R12 counter held after done", cnt_of(2), 10);
    endtask

    task automatic t_feature_zero();
        int cyc; bit b1;
        set_feat(0, 0);
        run(10, cyc, b1);
        check_eq("R2 feature 0 gives no firing", int'(class_cnt != '0), 0);
        check_eq("R9 all-zero tie gives index 0", int'(class_idx), 0);
    endtask

    task automatic t_multi_input();
        int cyc; bit b1;
        set_feat(0, 255); set_feat(5, 255); set_feat(6, 255); set_feat(7, 255);
        run(12, cyc, b1);
        check_eq("R4 hidden 7 vs 6 fires, class 4", cnt_of(4), 12);
        check_eq("R5 class 2 alongside", cnt_of(2), 12);
        check_eq("R9 tie resolves to lowest index", int'(class_idx), 2);
        set_feat(0, 0);
        run(12, cyc, b1);
        check_eq("R9 class 4 sole winner", int'(class_idx), 4);
        set_wt(0, 3, 7, 0, 4);
        set_feat(0, 255);
        run(12, cyc, b1);
        check_eq("R4 hidden tie at 7 vs 7 gives 0", cnt_of(4), 0);
        set_wt(0, 3, 7, 0, 3);
        set_feat(5, 0); set_feat(6, 0); set_feat(7, 0);
    endtask

    task automatic t_max_frames();
        int cyc; bit b1;
        run(255, cyc, b1);
        check_eq("R3 counter reaches 255 without wrap", cnt_of(2), 255);
        check_eq("R7 done cycle for 255 frames", cyc, 766);
    endtask

    task automatic t_zero_frames();
        int cyc; bit b1;
        run(0, cyc, b1);
        check_eq("R8 zero frames done in first cycle", cyc, 1);
        check_eq("R8 zero frames clears counters", int'(class_cnt != '0), 0);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        @(negedge clk);
        start = 1'b1; frames = 8'd20;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        repeat (4) begin @(negedge clk); cyc++; end
        feat_we = 1'b1; feat_addr = 5'd0; feat_val = 8'd0;
        wt_we = 1'b1; wt_layer = 1'b1; wt_row = 4'd2; wt_col = 5'd0; wt_pos = 3'd0; wt_neg = 3'd0;
        start = 1'b1; frames = 8'd3;
        @(negedge clk); cyc++;
        feat_we = 1'b0; wt_we = 1'b0; start = 1'b0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        check_eq("R10 start while busy does not restart", cyc, 61);
        check_eq("R10 loads while busy leave the result", cnt_of(2), 20);
        // loads during the done cycle are also dropped
        feat_we = 1'b1; feat_addr = 5'd0; feat_val = 8'd0;
        @(negedge clk);
        feat_we = 1'b0;
        begin
            int c2; bit b1;
            run(4, c2, b1);
        end
        check_eq("R10 dropped loads not applied later", cnt_of(2), 4);
    endtask

    task automatic t_stochastic();
        int cyc; bit b1; int first;
        set_feat(0, 0);
        set_feat(10, 128);
        run(200, cyc, b1);
        first = cnt_of(3);
        check(first >= 60 && first <= 140, "R11 half-probability count in band", first, 100);
        check_eq("R2 other classes silent", cnt_of(2), 0);
        run(200, cyc, b1);
        check_eq("R11 reseeded run repeats count", cnt_of(3), first);
        set_feat(10, 255);
        run(200, cyc, b1);
        check_eq("R2 feature 255 always fires", cnt_of(3), 200);
        check_eq("R9 winner follows counts", int'(class_idx), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        clear_feats();
        t_load_weights();
        t_basic();
        t_hold();
        t_feature_zero();
        t_multi_input();
        t_max_frames();
        t_zero_frames();
        set_feat(0, 255);
        t_busy_ignore();
        t_stochastic();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule